// File: doc/BRIEF.md
# CPU Clock Prescaler with Peripheral Clock Gating

This block sits beside the master clock of a chip and produces synchronous clock-enable strobes, one for the CPU and one for each peripheral. A divider code of `DIV_W` bits (3 by default) slows the CPU alone. Code n gives one CPU enable every 2^n master cycles, from divide-by-1 up to divide-by-128. A gating mask with one bit per peripheral connects or disconnects each peripheral from the master rate. Software can change either setting at any time through a single write port.

A new divider code is held pending until the current divided period ends, so the CPU never sees a shortened period. The power-mode input selects Run, Wait or one of two halt-class modes. In Wait the CPU enable is held low and the peripherals keep following the mask. In a halt-class mode every enable is held low. The divider never changes any peripheral enable.

Top module: `cpuclk_gate_ctrl`

## Requirements
- R1: After reset the divider code is 0 and every mask bit is 1, so in Run `cpu_ce` is high on every cycle and every bit of `periph_ce` is high.
- R2: A write with `wr_sel`=0 loads the divider code from `wr_data[DIV_W-1:0]`. With code n active in Run, `cpu_ce` pulses once every 2^n master cycles, and never more or less often.
- R3: A divider write takes effect only at the next `cpu_ce` pulse. The gap ending at that pulse keeps the old length, and the gaps after it have the new length.
- R4: Writing code 0 returns the CPU to full rate. After the next pulse, `cpu_ce` is high on every Run cycle.
- R5: Outside the halt-class modes, `periph_ce[i]` equals mask bit i on every cycle, whatever the divider code.
- R6: A write with `wr_sel`=1 loads the mask from `wr_data` (bit i belongs to peripheral i), in any mode. The new mask shows on `periph_ce` in the cycle after the write edge. Without such a write the mask holds.
- R7: With `pwr_mode`=1 (Wait), `cpu_ce` stays low whatever the divider code, and `periph_ce` follows the mask.
- R8: With `pwr_mode`=2 or 3 (halt-class), `cpu_ce` and every bit of `periph_ce` stay low. `pwr_mode`=0 is Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 divider code, 1 gating mask |
| wr_data | input | NUM_PERIPH | Write data; the divider uses the low DIV_W bits |
| pwr_mode | input | 2 | 0 Run, 1 Wait, 2 and 3 halt-class |
| cpu_ce | output | 1 | CPU clock-enable strobe |
| periph_ce | output | NUM_PERIPH | Per-peripheral clock enables |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the counter never passes the terminal value of the active code;
- the active code changes only on a CPU pulse;
- register writes land one edge after the strobe;
- the mode gating of `cpu_ce` and `periph_ce` holds;
- code 0 in Run gives a pulse on every cycle.

The bench's scenarios are needed for the rest. They show the real pulse spacing for each code over a whole window. They show that a mid-period change finishes the old gap before the new spacing starts. They also show that a return to code 0 from the slowest code waits out the remaining 128-cycle period.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

   typedef enum logic [1:0] {
      PWR_RUN       = 2'd0,
      PWR_WAIT      = 2'd1,
      PWR_HALT      = 2'd2,
      PWR_HALT_DEEP = 2'd3
   } pwr_mode_e;

   function automatic logic mode_is_halt(input logic [1:0] m);
      return m[1];
   endfunction

   function automatic logic mode_is_run(input logic [1:0] m);
      return m == PWR_RUN;
   endfunction

endpackage

// File: rtl/cpuclk_cfg_regs.sv
module cpuclk_cfg_regs #(
   parameter int DIV_W      = 3,
   parameter int NUM_PERIPH = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  wr_sel,
   input  logic [NUM_PERIPH-1:0] wr_data,
   output logic [DIV_W-1:0]      div_req,
   output logic [NUM_PERIPH-1:0] gate_mask
);

   logic div_wr, mask_wr;

   assign div_wr  = wr_en & ~wr_sel;
   assign mask_wr = wr_en &  wr_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_req   <= '0;
         gate_mask <= '1;
      end else begin
         if (div_wr)  div_req   <= wr_data[DIV_W-1:0];
         if (mask_wr) gate_mask <= wr_data;
      end
   end

   AST_DIV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> div_req == $past(wr_data[DIV_W-1:0]));      // R2
   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> gate_mask == $past(wr_data));                 // R6
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel) |=> $stable(gate_mask));                         // R6

endmodule

// File: rtl/cpuclk_ratio_div.sv
module cpuclk_ratio_div #(
   parameter int DIV_W    = 3,
   parameter bit COUNT_UP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_req,
   output logic             tick,
   output logic [DIV_W-1:0] div_act
);

   localparam int CNT_W = (1 << DIV_W) - 1;

   function automatic logic [CNT_W-1:0] term_of(input logic [DIV_W-1:0] d);
      logic [CNT_W-1:0] t;
      t = '0;
      for (int i = 0; i < CNT_W; i++) begin
         if (i < int'(d)) t[i] = 1'b1;
      end
      return t;
   endfunction

   logic [CNT_W-1:0] cnt_q;

   generate
      if (COUNT_UP) begin : g_up
         assign tick = (cnt_q == term_of(div_act));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q   <= '0;
               div_act <= '0;
            end else if (tick) begin
               cnt_q   <= '0;
               div_act <= div_req;
            end else begin
               cnt_q   <= cnt_q + CNT_W'(1);
            end
         end
      end else begin : g_down
         assign tick = (cnt_q == '0);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q   <= '0;
               div_act <= '0;
            end else if (tick) begin
               cnt_q   <= term_of(div_req);
               div_act <= div_req;
            end else begin
               cnt_q   <= cnt_q - CNT_W'(1);
            end
         end
      end
   endgenerate

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= term_of(div_act));                                          // R2
   AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(div_act));                                         // R3
   AST_RATIO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> div_act == $past(div_req));                                 // R3

endmodule

// File: rtl/cpuclk_mode_gate.sv
module cpuclk_mode_gate
   import cpuclk_pkg::*;
#(
   parameter int NUM_PERIPH = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            pwr_mode,
   input  logic                  tick,
   input  logic [NUM_PERIPH-1:0] gate_mask,
   output logic                  cpu_ce,
   output logic [NUM_PERIPH-1:0] periph_ce
);

   logic run_w, halt_w;

   assign run_w  = mode_is_run(pwr_mode);
   assign halt_w = mode_is_halt(pwr_mode);
   assign cpu_ce = tick & run_w;

   generate
      for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_periph
         assign periph_ce[g] = gate_mask[g] & ~halt_w;
      end
   endgenerate

   AST_WAIT_CPU_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode == PWR_WAIT) |-> !cpu_ce);                                 // R7
   AST_HALT_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_mode[1] |-> (!cpu_ce && periph_ce == '0));                       // R8
   AST_MASK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_mode[1] |-> periph_ce == gate_mask);                            // R5

endmodule

// File: rtl/cpuclk_gate_ctrl.sv
module cpuclk_gate_ctrl
   import cpuclk_pkg::*;
#(
   parameter int DIV_W      = 3,
   parameter int NUM_PERIPH = 8,
   parameter bit COUNT_UP   = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  wr_sel,
   input  logic [NUM_PERIPH-1:0] wr_data,
   input  logic [1:0]            pwr_mode,
   output logic                  cpu_ce,
   output logic [NUM_PERIPH-1:0] periph_ce
);

   generate
      if (DIV_W < 1 || DIV_W > 5) begin : g_bad_div_w
         $error("DIV_W must lie in 1..5");
      end
      if (NUM_PERIPH < DIV_W || NUM_PERIPH > 64) begin : g_bad_periph
         $error("NUM_PERIPH must lie in DIV_W..64");
      end
   endgenerate

   logic [DIV_W-1:0]      div_req, div_act;
   logic [NUM_PERIPH-1:0] gate_mask;
   logic                  tick;

   cpuclk_cfg_regs #(
      .DIV_W      (DIV_W),
      .NUM_PERIPH (NUM_PERIPH)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .div_req   (div_req),
      .gate_mask (gate_mask)
   );

   cpuclk_ratio_div #(
      .DIV_W    (DIV_W),
      .COUNT_UP (COUNT_UP)
   ) div_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_req (div_req),
      .tick    (tick),
      .div_act (div_act)
   );

   cpuclk_mode_gate #(
      .NUM_PERIPH (NUM_PERIPH)
   ) gate_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_mode  (pwr_mode),
      .tick      (tick),
      .gate_mask (gate_mask),
      .cpu_ce    (cpu_ce),
      .periph_ce (periph_ce)
   );

   AST_FULL_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode == PWR_RUN && div_act == '0) |-> cpu_ce);                  // R4

endmodule

// File: tb/cpuclk_gate_ctrl_tb_top.sv
module cpuclk_gate_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic [1:0] pwr_mode = 2'd0;
   logic       cpu_ce;
   logic [7:0] periph_ce;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   cpuclk_gate_ctrl #(.DIV_W(3), .NUM_PERIPH(8), .COUNT_UP(1'b0)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .pwr_mode  (pwr_mode),
      .cpu_ce    (cpu_ce),
      .periph_ce (periph_ce)
   );

   // fields: [29:27] code, [26:25] mode, [24:17] mask, [16:8] pulses per 256, [7:0] expected enables
   localparam logic [29:0] VECS [9] = '{
      {3'd0, 2'd0, 8'hFF, 9'd256, 8'hFF},
      {3'd1, 2'd0, 8'h0F, 9'd128, 8'h0F},
      {3'd3, 2'd0, 8'h3C, 9'd32,  8'h3C},
      {3'd7, 2'd0, 8'h81, 9'd2,   8'h81},
      {3'd5, 2'd1, 8'h5A, 9'd0,   8'h5A},
      {3'd2, 2'd2, 8'hFF, 9'd0,   8'h00},
      {3'd6, 2'd3, 8'h33, 9'd0,   8'h00},
      {3'd4, 2'd1, 8'h00, 9'd0,   8'h00},
      {3'd2, 2'd0, 8'hC3, 9'd64,  8'hC3}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      wr_sel  = sel;
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic sync_pulse();
      while (!cpu_ce) @(negedge clk);
   endtask

   task automatic gap(output int g);
      g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (!cpu_ce);
   endtask

   initial begin
      int g;
      int pulses;
      int mism;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(cpu_ce == 1'b1, "R1 cpu_ce after reset", cpu_ce, 1);
      check(periph_ce == 8'hFF, "R1 periph_ce after reset", periph_ce, 8'hFF);
      pulses = 0;
      for (int i = 0; i < 16; i++) begin
         if (cpu_ce) pulses++;
         @(negedge clk);
      end
      check(pulses == 16, "R1 full rate after reset", pulses, 16);

      // table walk: R2 rates, R5 divider-independent gating, R7 wait, R8 halt
      for (int v = 0; v < 9; v++) begin
         logic [29:0] e;
         e = VECS[v];
         pwr_mode = 2'd0;
         wr(1'b0, {5'd0, e[29:27]});
         wr(1'b1, e[24:17]);
         repeat (260) @(negedge clk);
         pwr_mode = e[26:25];
         repeat (2) @(negedge clk);
         pulses = 0;
         mism = 0;
         for (int c = 0; c < 256; c++) begin
            if (cpu_ce) pulses++;
            if (periph_ce != e[7:0]) mism++;
            @(negedge clk);
         end
         check(pulses == int'(e[16:8]), $sformatf("R2/R7/R8 vec %0d cpu pulses", v),
               pulses, int'(e[16:8]));
         check(mism == 0, $sformatf("R5/R8 vec %0d periph_ce mismatches", v), mism, 0);
      end

      // R3: change from code 3 to code 1 on a pulse cycle
      pwr_mode = 2'd0;
      wr(1'b1, 8'hFF);
      wr(1'b0, 8'd3);
      repeat (300) @(negedge clk);
      sync_pulse();
      wr_sel = 1'b0; wr_data = 8'd1; wr_en = 1'b1;
      g = 0;
      do begin
         @(negedge clk);
         wr_en = 1'b0;
         g++;
      end while (!cpu_ce);
      check(g == 8, "R3 old gap kept", g, 8);
      gap(g);
      check(g == 2, "R3 new gap first", g, 2);
      gap(g);
      check(g == 2, "R3 new gap second", g, 2);

      // R4: back to code 0 from code 7 in the middle of a period
      wr(1'b0, 8'd7);
      repeat (300) @(negedge clk);
      sync_pulse();
      g = 0;
      do begin
         @(negedge clk);
         g++;
         if (g == 10) begin
            wr_sel = 1'b0; wr_data = 8'd0; wr_en = 1'b1;
         end else begin
            wr_en = 1'b0;
         end
      end while (!cpu_ce);
      check(g == 128, "R4 slow period completes", g, 128);
      pulses = 0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (cpu_ce) pulses++;
      end
      check(pulses == 16, "R4 full rate restored", pulses, 16);

      // R6: mask write in Run with a slow divider, then in Wait
      wr(1'b0, 8'd5);
      wr(1'b1, 8'hA5);
      check(periph_ce == 8'hA5, "R6 mask write in Run", periph_ce, 8'hA5);
      pwr_mode = 2'd1;
      @(negedge clk);
      wr(1'b1, 8'h3C);
      check(periph_ce == 8'h3C, "R6 mask write in Wait", periph_ce, 8'h3C);
      check(cpu_ce == 1'b0, "R7 cpu idle in Wait", cpu_ce, 0);
      // R6: divider write leaves mask untouched
      wr(1'b0, 8'd1);
      check(periph_ce == 8'h3C, "R6 mask held over divider write", periph_ce, 8'h3C);
      // R6: mask write during halt shows once the halt ends
      pwr_mode = 2'd2;
      wr(1'b1, 8'h96);
      check(periph_ce == 8'h00, "R8 halt hides mask", periph_ce, 0);
      pwr_mode = 2'd0;
      @(negedge clk);
      check(periph_ce == 8'h96, "R6 mask written in halt", periph_ce, 8'h96);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule